// File: doc/BRIEF.md
# I/O Vector Bit-Field Mover

This block moves bit fields between an 8-bit working value and one of two 8-bit I/O interface vector banks (a left bank and a right bank) that sit on a shared 9-bit-addressed I/O port. For an extract, it reads the selected bank into an internal byte latch. It then rotates the latched byte so the chosen field lands at bit 0 and masks the field to the requested length. For a merge, it reads the bank into the same latch and overlays a value field at the requested position, keeping all other bits. It then writes the merged byte back to the bank.

Field positions are numbered from the most significant bit: position 0 is bit 7 and position 7 is bit 0. The position given names the field's least significant bit, and the field extends toward the MSB. A length code of 0 stands for a full-width field. The surrounding processor supplies the bank selector bytes, the bank choice, the position, the length and the value. It pulses `start` and waits for `done`. Opcode decoding, arithmetic and sequencing are outside this block.

Top module: `ivx_field_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `port_rd`, `port_wr` and `done` are 0, and `field_out` is 0.
- R2: A `start` sampled while idle asserts `port_rd` for exactly one cycle, beginning on the cycle after `start`. When `bank_right` = 0, `port_addr` = {1'b0, `left_sel`}.
- R3: When `bank_right` = 1, `port_addr` = {1'b1, `right_sel`}. This is the right selector plus 0x100.
- R4: Extract (`op_merge` = 0): let s = 7 − `fld_lsb`. Two cycles after the read strobe, `done` pulses and `field_out` = (byte read, rotated right by s) AND (mask of the low L bits). L is the field length, and the rotate feeds bits leaving bit 0 back in at bit 7.
- R5: A `fld_len` code of 0 gives L = 8. Codes 1 to 7 give L equal to the code.
- R6: Merge (`op_merge` = 1): `port_wr` is high for exactly the one cycle that comes two cycles after the read strobe. It uses the same `port_addr`, and `port_wdata` = (read AND NOT M) OR ((`wr_value` << s) AND M), where M = (low L bits mask) << s, truncated to 8 bits.
- R7: `done` is a one-cycle pulse. After an extract it comes two cycles after the read strobe. After a merge it comes in the cycle after the write strobe.
- R8: `start` is ignored while an operation is in progress, so no extra read or write strobe follows.
- R9: `port_rd` and `port_wr` are never high together, and each strobe lasts one cycle.
- R10: `field_out` changes only together with an extract's `done`. A merge leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_merge | input | 1 | 0 = extract field, 1 = merge field |
| bank_right | input | 1 | 0 = left bank, 1 = right bank |
| fld_lsb | input | 3 | Field LSB position counted from MSB |
| fld_len | input | 3 | Field length code, 0 means 8 |
| left_sel | input | 8 | Left bank port selector |
| right_sel | input | 8 | Right bank port selector |
| wr_value | input | 8 | Value whose low bits form the merged field |
| port_rdata | input | 8 | Read data from the I/O port |
| port_rd | output | 1 | One-cycle read strobe |
| port_wr | output | 1 | One-cycle write strobe |
| port_addr | output | 9 | Registered I/O port address |
| port_wdata | output | 8 | Merged byte written to the port |
| field_out | output | 8 | Extracted, right-aligned field |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong latch value or a wrong rotate amount shows up on the ports exactly two cycles after the read strobe. It appears either as an incorrect `field_out` alongside `done` or as incorrect bits in `port_wdata` alongside `port_wr`. Untouched-bit corruption during a merge is seen in that same write cycle. A sequencing fault, such as a lost or extra strobe or a mistimed `done`, appears within one to three cycles of `start`. An address fault is visible on the read strobe itself, one cycle after `start`. Random positions, lengths, banks and read bytes are mixed with full-width, single-bit and top-overflowing fields.

// File: rtl/ivx_pkg.sv
package ivx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_WRITE = 2'd3
  } ivx_state_e;

  typedef enum logic {
    OP_EXTRACT = 1'b0,
    OP_MERGE   = 1'b1
  } ivx_op_e;
endpackage

// File: rtl/ivx_len_mask.sv
module ivx_len_mask #(
  parameter int W     = 8,
  parameter int POS_W = $clog2(W)
) (
  input  logic [POS_W-1:0] len_code,
  output logic [W-1:0]     mask
);
  localparam logic [POS_W:0] FULL = (POS_W+1)'(W);
  logic [POS_W:0] len_eff;

  always_comb begin
    len_eff = (len_code == '0) ? FULL : {1'b0, len_code};
    mask    = {W{1'b1}} >> (FULL - len_eff);
  end
endmodule

// File: rtl/ivx_extract.sv
module ivx_extract #(
  parameter int W     = 8,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     src,
  input  logic [POS_W-1:0] lsb_pos,
  input  logic [POS_W-1:0] len_code,
  output logic [W-1:0]     field
);
  localparam logic [POS_W-1:0] TOP = POS_W'(W-1);
  logic [POS_W-1:0] shamt;
  logic [W-1:0]     rotated;
  logic [W-1:0]     mask;

  ivx_len_mask #(.W(W), .POS_W(POS_W)) u_mask (
    .len_code (len_code),
    .mask     (mask)
  );

  always_comb begin
    shamt   = TOP - lsb_pos;
    rotated = (src >> shamt) | (src << (W - int'(shamt)));
    field   = rotated & mask;
  end
endmodule

// File: rtl/ivx_merge.sv
module ivx_merge #(
  parameter int W     = 8,
  parameter int POS_W = $clog2(W)
) (
  input  logic [W-1:0]     base,
  input  logic [W-1:0]     value,
  input  logic [POS_W-1:0] lsb_pos,
  input  logic [POS_W-1:0] len_code,
  output logic [W-1:0]     merged
);
  localparam logic [POS_W-1:0] TOP = POS_W'(W-1);
  logic [POS_W-1:0] shamt;
  logic [W-1:0]     low_mask;
  logic [W-1:0]     pos_mask;
  logic [W-1:0]     pos_val;

  ivx_len_mask #(.W(W), .POS_W(POS_W)) u_mask (
    .len_code (len_code),
    .mask     (low_mask)
  );

  always_comb begin
    shamt    = TOP - lsb_pos;
    pos_mask = low_mask << shamt;
    pos_val  = value << shamt;
    merged   = (base & ~pos_mask) | (pos_val & pos_mask);
  end
endmodule

// File: rtl/ivx_field_unit.sv
module ivx_field_unit #(
  parameter int W      = 8,
  parameter int SEL_W  = 8,
  parameter int POS_W  = $clog2(W),
  parameter int ADDR_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_merge,
  input  logic              bank_right,
  input  logic [POS_W-1:0]  fld_lsb,
  input  logic [POS_W-1:0]  fld_len,
  input  logic [SEL_W-1:0]  left_sel,
  input  logic [SEL_W-1:0]  right_sel,
  input  logic [W-1:0]      wr_value,
  input  logic [W-1:0]      port_rdata,
  output logic              port_rd,
  output logic              port_wr,
  output logic [ADDR_W-1:0] port_addr,
  output logic [W-1:0]      port_wdata,
  output logic [W-1:0]      field_out,
  output logic              done
);
  import ivx_pkg::*;

  ivx_state_e       state_q;
  ivx_op_e          op_q;
  logic [POS_W-1:0] lsb_q;
  logic [POS_W-1:0] len_q;
  logic [W-1:0]     val_q;
  logic [W-1:0]     vec_latch;
  logic [W-1:0]     ext_field;
  logic [W-1:0]     mrg_byte;

  ivx_extract #(.W(W), .POS_W(POS_W)) u_extract (
    .src      (vec_latch),
    .lsb_pos  (lsb_q),
    .len_code (len_q),
    .field    (ext_field)
  );

  ivx_merge #(.W(W), .POS_W(POS_W)) u_merge (
    .base     (vec_latch),
    .value    (val_q),
    .lsb_pos  (lsb_q),
    .len_code (len_q),
    .merged   (mrg_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_EXTRACT;
      lsb_q      <= '0;
      len_q      <= '0;
      val_q      <= '0;
      vec_latch  <= '0;
      port_rd    <= 1'b0;
      port_wr    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
      field_out  <= '0;
      done       <= 1'b0;
    end else begin
      port_rd <= 1'b0;
      port_wr <= 1'b0;
      done    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            op_q      <= op_merge ? OP_MERGE : OP_EXTRACT;
            lsb_q     <= fld_lsb;
            len_q     <= fld_len;
            val_q     <= wr_value;
            port_addr <= bank_right ? {1'b1, right_sel} : {1'b0, left_sel};
            port_rd   <= 1'b1;
            state_q   <= ST_READ;
          end
        end
        ST_READ: begin
          vec_latch <= port_rdata;
          state_q   <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op_q == OP_MERGE) begin
            vec_latch  <= mrg_byte;
            port_wdata <= mrg_byte;
            port_wr    <= 1'b1;
            state_q    <= ST_WRITE;
          end else begin
            field_out <= ext_field;
            done      <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_WRITE: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivx_field_unit_chk.sv
module ivx_field_unit_chk #(
  parameter int W      = 8,
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              port_rd,
  input logic              port_wr,
  input logic [ADDR_W-1:0] port_addr,
  input logic [W-1:0]      field_out,
  input logic              done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!port_rd && !port_wr && !done && field_out == '0));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(port_rd && port_wr));

  // R9
  rd_single_chk: assert property (@(posedge clk) disable iff (rst)
    port_rd |=> !port_rd);

  // R6
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    port_wr |-> $past(port_rd, 2));

  // R6
  wr_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    port_wr |-> $stable(port_addr));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_origin_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(port_rd, 2) || $past(port_wr)));

  // R10
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(field_out));
endmodule

bind ivx_field_unit ivx_field_unit_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .port_rd   (port_rd),
  .port_wr   (port_wr),
  .port_addr (port_addr),
  .field_out (field_out),
  .done      (done)
);

// File: tb/ivx_field_unit_bench.sv
`timescale 1ns/1ps
module ivx_field_unit_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       op_merge = 1'b0;
  logic       bank_right = 1'b0;
  logic [2:0] fld_lsb = '0;
  logic [2:0] fld_len = '0;
  logic [7:0] left_sel = '0;
  logic [7:0] right_sel = '0;
  logic [7:0] wr_value = '0;
  logic [7:0] port_rdata = '0;
  logic       port_rd, port_wr, done;
  logic [8:0] port_addr;
  logic [7:0] port_wdata, field_out;

  int checks = 0;
  int errors = 0;
  logic [7:0] prev_field = '0;

  always #2.5 clk = ~clk;

  ivx_field_unit u_ivx_field_unit (
    .clk(clk), .rst(rst), .start(start), .op_merge(op_merge),
    .bank_right(bank_right), .fld_lsb(fld_lsb), .fld_len(fld_len),
    .left_sel(left_sel), .right_sel(right_sel), .wr_value(wr_value),
    .port_rdata(port_rdata), .port_rd(port_rd), .port_wr(port_wr),
    .port_addr(port_addr), .port_wdata(port_wdata),
    .field_out(field_out), .done(done)
  );

  function automatic int len_of(input logic [2:0] code);
    return (code == 3'd0) ? 8 : int'(code);
  endfunction

  function automatic logic [7:0] exp_extract(input logic [7:0] b, input logic [2:0] lsb,
                                             input logic [2:0] code);
    logic [7:0] r;
    int s = 7 - int'(lsb);
    for (int i = 0; i < 8; i++)
      r[i] = (i < len_of(code)) ? b[(i + s) % 8] : 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] exp_merge(input logic [7:0] b, input logic [7:0] v,
                                           input logic [2:0] lsb, input logic [2:0] code);
    logic [7:0] r;
    int s = 7 - int'(lsb);
    for (int i = 0; i < 8; i++) begin
      int p = i - s;
      r[i] = (p >= 0 && p < len_of(code)) ? v[p] : b[i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit mrg, input bit rb, input logic [2:0] lsb,
                        input logic [2:0] code, input logic [7:0] ls,
                        input logic [7:0] rs, input logic [7:0] val,
                        input logic [7:0] rdat, input bit poke);
    logic [8:0] ea = rb ? {1'b1, rs} : {1'b0, ls};
    op_merge = mrg; bank_right = rb; fld_lsb = lsb; fld_len = code;
    left_sel = ls; right_sel = rs; wr_value = val; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_merge = ~mrg; fld_lsb = ~lsb; fld_len = ~code; wr_value = ~val;
    left_sel = ~ls; right_sel = ~rs; bank_right = ~rb;
    check(rb ? "R3 read addr" : "R2 read addr", 32'(port_addr), 32'(ea));
    check("R2 read strobe", 32'(port_rd), 32'd1);
    port_rdata = rdat;
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    port_rdata = ~rdat;
    check("R9 read strobe one cycle", 32'(port_rd), 32'd0);
    check("R7 no early done", 32'(done), 32'd0);
    @(negedge clk);
    if (!mrg) begin
      check("R7 extract done", 32'(done), 32'd1);
      check(code == 3'd0 ? "R5 full-width extract" : "R4 extract field",
            32'(field_out), 32'(exp_extract(rdat, lsb, code)));
      check("R9 no write on extract", 32'(port_wr), 32'd0);
      prev_field = exp_extract(rdat, lsb, code);
    end else begin
      check("R6 write strobe", 32'(port_wr), 32'd1);
      check("R6 write addr", 32'(port_addr), 32'(ea));
      check(code == 3'd0 ? "R5 full-width merge" : "R6 merge data",
            32'(port_wdata), 32'(exp_merge(rdat, val, lsb, code)));
      check("R7 no done with write", 32'(done), 32'd0);
      @(negedge clk);
      check("R7 merge done", 32'(done), 32'd1);
      check("R9 write strobe one cycle", 32'(port_wr), 32'd0);
      check("R10 merge keeps field", 32'(field_out), 32'(prev_field));
    end
    if (poke) begin
      @(negedge clk);
      check("R8 busy start ignored rd", 32'(port_rd), 32'd0);
      check("R8 busy start ignored wr", 32'(port_wr), 32'd0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 rd in reset", 32'(port_rd), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd after reset", 32'(port_rd), 32'd0);
    check("R1 wr after reset", 32'(port_wr), 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 field after reset", 32'(field_out), 32'd0);

    // directed corners
    run_op(0, 0, 3'd7, 3'd1, 8'h12, 8'h34, 8'h00, 8'hA5, 0); // R4 bit0
    run_op(0, 1, 3'd0, 3'd1, 8'h12, 8'h34, 8'h00, 8'h80, 0); // R4 MSB single bit
    run_op(0, 0, 3'd3, 3'd0, 8'hFF, 8'h00, 8'h00, 8'h3C, 0); // R5 rotate full
    run_op(1, 1, 3'd7, 3'd0, 8'h01, 8'hFE, 8'h5A, 8'hC3, 0); // R5 full overwrite
    run_op(1, 0, 3'd2, 3'd4, 8'h77, 8'h00, 8'hFF, 8'h00, 0); // R6 field over top
    run_op(1, 1, 3'd5, 3'd2, 8'h00, 8'hAA, 8'h01, 8'hFF, 1); // R8 poke during merge
    run_op(0, 0, 3'd4, 3'd3, 8'h55, 8'h66, 8'h00, 8'h9B, 1); // R8 poke during extract

    for (int n = 0; n < 300; n++) begin
      run_op(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
             3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
             8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
             ($urandom_range(0, 7) == 0));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule